// File: doc/BRIEF.md
# Decoder Event Status and Interrupt Register

This block is the software-facing event register pair for a bitstream decoder engine. The engine reports six kinds of event as one-cycle pulses. Each pulse latches a sticky bit in an event register. A second register holds one enable bit for each event. One level-sensitive interrupt line is raised while any latched event has its enable bit set.

Software reads both registers through a simple word-addressed read port. It acknowledges events by writing ones to the event register. Bit 0 reports that a command has finished, and it behaves differently from the other bits. Software writes to bit 0 do nothing. Only the engine's command-issue strobe clears it, so that software cannot lose a completion before the next command starts. When a hardware set and a clear reach the same bit in the same cycle, the set takes priority. This ensures that no event is dropped.

Word 0 holds the event register and word 1 holds the enable register. Every other word, and every bit above bit 5, reads as zero and ignores writes.

Top module: `decstat_regs`

## Requirements
- R1: After a synchronous active-low reset, the event register (word 0) and the enable register (word 1) both read 0 and `irq` is low.
- R2: A one on `evt_set[i]` at a clock edge sets event bit i. The bit stays set until it is cleared, and it is readable at word 0, bit i.
- R3: Writing word 0 with a one in data bit i, for i in 1 to 5, clears event bit i. A zero in a data bit leaves that event bit unchanged.
- R4: Event bit 0 (command done) ignores software writes of either value. A one on `cmd_issue` at a clock edge clears it.
- R5: If a set pulse arrives in the same cycle as a clear of the same bit, the bit ends set. The clear can be a write-one clear on bits 1 to 5 or `cmd_issue` on bit 0.
- R6: Writing word 1 loads data bits 5..0 into the enable register. Reading word 1 returns those bits with bits 31..6 as zero.
- R7: `irq` is high exactly while at least one event bit and its enable bit are both one. It stays high until every enabled pending event is cleared or disabled.
- R8: Reads of words 2 and 3 return zero, and writes to them change neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Word index for writes |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Word index for reads |
| rd_data | output | 32 | Read data, combinational from rd_addr |
| evt_set | input | 6 | One-cycle event pulses from the engine |
| cmd_issue | input | 1 | New-command strobe; clears bit 0 |
| irq | output | 1 | Level interrupt |

## Verification
The bench sets events with single pulses and with several bits at once. It applies write-one clears with all-zero, single-bit and all-ones data, which separates the clearable bits from the protected bit 0. It presents sets and clears in the same cycle on both the write path and the command path to expose a wrong priority. It then varies the enable pattern over several pending sets. This shows whether `irq` follows only the enabled bits, and whether it stays high while one enabled event is still pending after another is cleared.

// File: rtl/decstat_pkg.sv
// Shared definitions for the decoder event register block.
// Assumes word-addressed access; only words 0 and 1 are populated.
package decstat_pkg;
    localparam int unsigned STAT_WORD = 0;
    localparam int unsigned MASK_WORD = 1;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_STAT = 2'd1,
        SEL_MASK = 2'd2
    } reg_sel_e;

    // Map a word index onto the register it selects.
    function automatic reg_sel_e word_decode(input int unsigned idx);
        if (idx == STAT_WORD) return SEL_STAT;
        if (idx == MASK_WORD) return SEL_MASK;
        return SEL_NONE;
    endfunction
endpackage

// File: rtl/decstat_event_reg.sv
// Sticky event register. Each bit is set by a hardware pulse and cleared by
// clr_req. A set always wins over a clear in the same cycle.
// Assumes clr_req already carries the right clear source for every bit.
module decstat_event_reg #(
    parameter int unsigned EVT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [EVT_W-1:0] evt_set,
    input  logic [EVT_W-1:0] clr_req,
    output logic [EVT_W-1:0] status_q
);
    logic [EVT_W-1:0] status_d;

    // Next state per bit: set has priority, then clear, else hold.
    for (genvar i = 0; i < EVT_W; i++) begin : g_bit
        assign status_d[i] = evt_set[i] | (status_q[i] & ~clr_req[i]);
    end

    // Register the event bits.
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= status_d;
    end

    // R5
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_set != '0) |=> ((status_q & $past(evt_set)) == $past(evt_set)));

    // R2
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(status_q) & ~$past(clr_req) & ~status_q) == '0));

    // R4
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q[0] && !clr_req[0]) |=> status_q[0]);
endmodule

// File: rtl/decstat_mask_reg.sv
// Interrupt enable register: loaded in full from the low write-data bits.
// Assumes wr_mask is a one-cycle qualified write strobe.
module decstat_mask_reg #(
    parameter int unsigned EVT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_mask,
    input  logic [EVT_W-1:0] wr_bits,
    output logic [EVT_W-1:0] mask_q
);
    // Load enables on a write, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '0;
        else if (wr_mask) mask_q <= wr_bits;
    end

    // R6
    mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_mask |=> (mask_q == $past(wr_bits)));
endmodule

// File: rtl/decstat_rdmux.sv
// Read multiplexer: zero-extends the populated registers and returns zero
// for all unpopulated words. Purely combinational.
module decstat_rdmux
    import decstat_pkg::*;
#(
    parameter int unsigned EVT_W  = 6,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 2
) (
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [EVT_W-1:0]  status_q,
    input  logic [EVT_W-1:0]  mask_q,
    output logic [DATA_W-1:0] rd_data
);
    // Select the addressed register or zero.
    always_comb begin
        rd_data = '0;
        unique case (word_decode(int'(rd_addr)))
            SEL_STAT: rd_data[EVT_W-1:0] = status_q;
            SEL_MASK: rd_data[EVT_W-1:0] = mask_q;
            default:  rd_data = '0;
        endcase
    end

    // R8
    unused_zero_chk: assert final (int'(rd_addr) <= int'(MASK_WORD) || rd_data == '0);
endmodule

// File: rtl/decstat_regs.sv
// Top of the decoder event status / interrupt enable register pair.
// Decodes writes, routes the per-bit clear sources, and drives the level
// interrupt from registered state. Assumes EVT_W <= DATA_W.
module decstat_regs
    import decstat_pkg::*;
#(
    parameter int unsigned EVT_W  = 6,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic [EVT_W-1:0]  evt_set,
    input  logic              cmd_issue,
    output logic              irq
);
    localparam int unsigned DONE_BIT = 0;

    reg_sel_e         wsel;
    logic             wr_stat;
    logic             wr_mask;
    logic [EVT_W-1:0] clr_req;
    logic [EVT_W-1:0] status_q;
    logic [EVT_W-1:0] mask_q;

    // Decode the write target.
    always_comb begin
        wsel    = wr_en ? word_decode(int'(wr_addr)) : SEL_NONE;
        wr_stat = (wsel == SEL_STAT);
        wr_mask = (wsel == SEL_MASK);
    end

    // Clear sources: command strobe for bit 0, write-one for the rest.
    for (genvar i = 0; i < EVT_W; i++) begin : g_clr
        if (i == DONE_BIT) begin : g_done
            assign clr_req[i] = cmd_issue;
        end else begin : g_w1c
            assign clr_req[i] = wr_stat & wr_data[i];
        end
    end

    decstat_event_reg #(.EVT_W(EVT_W)) u_event (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt_set  (evt_set),
        .clr_req  (clr_req),
        .status_q (status_q)
    );

    decstat_mask_reg #(.EVT_W(EVT_W)) u_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_mask (wr_mask),
        .wr_bits (wr_data[EVT_W-1:0]),
        .mask_q  (mask_q)
    );

    decstat_rdmux #(.EVT_W(EVT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rdmux (
        .rd_addr  (rd_addr),
        .status_q (status_q),
        .mask_q   (mask_q),
        .rd_data  (rd_data)
    );

    // Level interrupt from registered state only.
    assign irq = |(status_q & mask_q);

    // R7
    irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(evt_set) != '0 || $past(wr_mask)));

    // R3
    w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && ((wr_data[EVT_W-1:1] & ~evt_set[EVT_W-1:1]) != '0))
        |=> ((status_q[EVT_W-1:1] & $past(wr_data[EVT_W-1:1] & ~evt_set[EVT_W-1:1])) == '0));
endmodule

// File: tb/decstat_regs_test.sv
module decstat_regs_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [5:0]  evt_set = '0;
    logic        cmd_issue = 1'b0;
    logic        irq;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    logic [31:0] exp_q[$];
    int          kind_q[$];
    string       tag_q[$];
    event        chk_ev;

    always #4 clk = ~clk;

    decstat_regs uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .evt_set(evt_set), .cmd_issue(cmd_issue), .irq(irq)
    );

    // Monitor: pop expected items and compare with the design outputs.
    initial begin
        forever begin
            @(chk_ev);
            #1;
            while (exp_q.size() > 0) begin
                logic [31:0] e;
                logic [31:0] a;
                int k;
                string t;
                e = exp_q.pop_front();
                k = kind_q.pop_front();
                t = tag_q.pop_front();
                a = (k == 0) ? rd_data : {31'b0, irq};
                total++;
                if (a !== e) begin
                    bad++;
                    $display("FAIL %s actual=%h expected=%h", t, a, e);
                end
            end
        end
    end

    // Driver: read a word and queue the expected value.
    task automatic exp_rd(input logic [1:0] a, input logic [31:0] e, input string t);
        rd_addr = a;
        exp_q.push_back(e); kind_q.push_back(0); tag_q.push_back(t);
        ->chk_ev;
        #3;
    endtask

    task automatic exp_irq(input logic e, input string t);
        exp_q.push_back({31'b0, e}); kind_q.push_back(1); tag_q.push_back(t);
        ->chk_ev;
        #3;
    endtask

    // One clock of stimulus, applied at a falling edge and removed at the next.
    task automatic cyc(input logic [5:0] s, input logic c, input logic we,
                       input logic [1:0] wa, input logic [31:0] wd);
        @(negedge clk);
        evt_set = s; cmd_issue = c; wr_en = we; wr_addr = wa; wr_data = wd;
        @(negedge clk);
        evt_set = '0; cmd_issue = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        exp_rd(2'd0, 32'h0, "R1 status after reset");
        exp_rd(2'd1, 32'h0, "R1 mask after reset");
        exp_irq(1'b0, "R1 irq after reset");

        cyc(6'h26, 1'b0, 1'b0, 2'd0, 32'h0);
        exp_rd(2'd0, 32'h26, "R2 multi-bit set");
        exp_irq(1'b0, "R7 no irq with mask zero");

        cyc(6'h00, 1'b0, 1'b1, 2'd0, 32'h0);
        exp_rd(2'd0, 32'h26, "R3 zero write no effect");
        cyc(6'h00, 1'b0, 1'b1, 2'd0, 32'h4);
        exp_rd(2'd0, 32'h22, "R3 clear bit 2");

        cyc(6'h00, 1'b0, 1'b1, 2'd1, 32'hFFFF_FFFF);
        exp_rd(2'd1, 32'h3F, "R6 mask readback upper zero");
        exp_irq(1'b1, "R7 irq with enabled pending");

        cyc(6'h01, 1'b0, 1'b0, 2'd0, 32'h0);
        exp_rd(2'd0, 32'h23, "R2 set done bit");
        cyc(6'h00, 1'b0, 1'b1, 2'd0, 32'h1);
        exp_rd(2'd0, 32'h23, "R4 write ignored on done bit");
        cyc(6'h00, 1'b1, 1'b0, 2'd0, 32'h0);
        exp_rd(2'd0, 32'h22, "R4 cmd clears done bit");

        cyc(6'h02, 1'b0, 1'b1, 2'd0, 32'h2);
        exp_rd(2'd0, 32'h22, "R5 set beats write clear");
        cyc(6'h01, 1'b1, 1'b0, 2'd0, 32'h0);
        exp_rd(2'd0, 32'h23, "R5 set beats cmd clear");

        cyc(6'h00, 1'b0, 1'b1, 2'd0, 32'hFFFF_FFFF);
        exp_rd(2'd0, 32'h01, "R3 all-ones clears 1..5 only");
        exp_irq(1'b1, "R7 irq from done bit");
        cyc(6'h00, 1'b0, 1'b1, 2'd1, 32'h0);
        exp_irq(1'b0, "R7 irq off when disabled");
        cyc(6'h00, 1'b0, 1'b1, 2'd1, 32'h1);
        exp_irq(1'b1, "R7 irq on when re-enabled");
        cyc(6'h00, 1'b1, 1'b0, 2'd0, 32'h0);
        exp_rd(2'd0, 32'h0, "R4 cmd clears done again");
        exp_irq(1'b0, "R7 irq off after clear");

        cyc(6'h00, 1'b0, 1'b1, 2'd2, 32'hFFFF_FFFF);
        cyc(6'h00, 1'b0, 1'b1, 2'd3, 32'hFFFF_FFFF);
        exp_rd(2'd2, 32'h0, "R8 word 2 reads zero");
        exp_rd(2'd3, 32'h0, "R8 word 3 reads zero");
        exp_rd(2'd0, 32'h0, "R8 status untouched");
        exp_rd(2'd1, 32'h1, "R8 mask untouched");

        cyc(6'h00, 1'b0, 1'b1, 2'd1, 32'h30);
        cyc(6'h3E, 1'b0, 1'b0, 2'd0, 32'h0);
        exp_irq(1'b1, "R7 two enabled pending");
        cyc(6'h00, 1'b0, 1'b1, 2'd0, 32'h20);
        exp_irq(1'b1, "R7 held by remaining enabled bit");
        cyc(6'h00, 1'b0, 1'b1, 2'd0, 32'h10);
        exp_irq(1'b0, "R7 low with only disabled pending");
        exp_rd(2'd0, 32'h0E, "R2 disabled bits still pending");

        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        exp_rd(2'd0, 32'h0, "R1 status after second reset");
        exp_rd(2'd1, 32'h0, "R1 mask after second reset");

        #10;
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog R1 actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule